// File: doc/BRIEF.md
# Masked Address/Data Breakpoint Comparator

This block watches every access on a 32-bit processor bus and emits a one-clock break request when the access matches one programmed breakpoint channel. The channel holds a reference address and a reference data word, each with a per-bit mask in which a 1 excludes that bit from the comparison. A control register sets the kinds of access that may trigger (read, write or both), an optional operand size that the access must have, and whether the data bus takes part in the match.

When data takes part, the size picks the byte lanes to compare. A longword compares all 32 bits and a halfword compares bits 15:0. A byte compares bits 15:8 at an even address and bits 7:0 at an odd address, so the reference byte must be placed in the matching lane of the data register. Software programs the channel through a small synchronous write port with a combinational read-back.

Top module: `brk_cmp_top`

## Requirements
- R1: After reset, all five registers read back as zero and `brk_o` is low.
- R2: Writes with `reg_we` high store `reg_wdata` at offset 0x00 (reference address), 0x04 (address mask), 0x08 (reference data), 0x0C (data mask) or 0x10 (control). Reads return the stored value, with control bits 31:5 reading as zero. Any other offset reads as zero.
- R3: The address condition holds when `((bus_addr ^ ref_addr) & ~addr_mask) == 0`.
- R4: With data enabled and longword size selected (control[1:0]=3), the data condition is `((bus_data ^ ref_data) & ~data_mask) == 0` over all 32 bits.
- R5: With data enabled and halfword size selected (control[1:0]=2), only bits 15:0 are compared, using the same masked rule.
- R6: With data enabled and byte size selected (control[1:0]=1), an even `bus_addr` compares bits 15:8 only.
- R7: With byte size selected, an odd `bus_addr` compares bits 7:0 only.
- R8: A nonzero control[1:0] requires `bus_size` (1 byte, 2 halfword, 3 longword) to equal it. When control[1:0]=0, the data compare is disabled even if control[2] (data enable) is set.
- R9: control[3] allows reads (`bus_wr`=0) to trigger and control[4] allows writes (`bus_wr`=1) to trigger. With both bits clear, no access breaks.
- R10: `brk_o` is high for exactly the one clock after a `bus_valid` access that meets every enabled condition, and it never rises without a valid access.
- R11: A register write in the same cycle as a bus access does not affect that access. It applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Monitored access valid |
| bus_addr | input | 32 | Monitored access address |
| bus_data | input | 32 | Monitored access data |
| bus_size | input | 2 | Access size: 1 byte, 2 halfword, 3 longword |
| bus_wr | input | 1 | 1 = write, 0 = read |
| brk_o | output | 1 | Break request pulse |

## Verification
The break pulse is registered once, so it is due in the cycle after the access strobe. Register read data is combinational and is due in the same cycle as the offset. A register write lands on the clock edge that ends its strobe cycle. The bench drives stimulus on falling edges. It samples `brk_o` on the falling edge one clock after the access, then again one clock later to confirm that the pulse is gone. Read data is sampled a short delay after the offset is applied, and the bench waits several clocks after reset release to cover the two-stage reset synchroniser.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } brk_size_e;

  // control layout, LSB first: size[1:0], data_en[2], on_rd[3], on_wr[4]
  typedef struct packed {
    logic      on_wr;
    logic      on_rd;
    logic      data_en;
    brk_size_e size;
  } brk_ctl_t;

  localparam int CTL_W = $bits(brk_ctl_t);

  localparam logic [4:0] OFF_ADDR  = 5'h00;
  localparam logic [4:0] OFF_AMASK = 5'h04;
  localparam logic [4:0] OFF_DATA  = 5'h08;
  localparam logic [4:0] OFF_DMASK = 5'h0C;
  localparam logic [4:0] OFF_CTL   = 5'h10;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [DW-1:0]  ref_addr_o,
  output logic [DW-1:0]  addr_mask_o,
  output logic [DW-1:0]  ref_data_o,
  output logic [DW-1:0]  data_mask_o,
  output brk_ctl_t       ctl_o
);
  localparam int PAD_W = DW - CTL_W;

  logic [DW-1:0] ra_q, am_q, rd_q, dm_q;
  logic [DW-1:0] ra_d, am_d, rd_d, dm_d;
  brk_ctl_t      ctl_q, ctl_d;
  logic          en_ra, en_am, en_rd, en_dm, en_ctl;

  // clock enables per register
  always_comb begin
    en_ra  = reg_we && (reg_addr == OFF_ADDR);
    en_am  = reg_we && (reg_addr == OFF_AMASK);
    en_rd  = reg_we && (reg_addr == OFF_DATA);
    en_dm  = reg_we && (reg_addr == OFF_DMASK);
    en_ctl = reg_we && (reg_addr == OFF_CTL);
  end

  // next-state
  always_comb begin
    ra_d  = en_ra  ? reg_wdata : ra_q;
    am_d  = en_am  ? reg_wdata : am_q;
    rd_d  = en_rd  ? reg_wdata : rd_q;
    dm_d  = en_dm  ? reg_wdata : dm_q;
    ctl_d = en_ctl ? brk_ctl_t'(reg_wdata[CTL_W-1:0]) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q  <= '0;
      am_q  <= '0;
      rd_q  <= '0;
      dm_q  <= '0;
      ctl_q <= '0;
    end else begin
      ra_q  <= ra_d;
      am_q  <= am_d;
      rd_q  <= rd_d;
      dm_q  <= dm_d;
      ctl_q <= ctl_d;
    end
  end

  // read-back mux
  always_comb begin
    unique case (reg_addr)
      OFF_ADDR:  reg_rdata = ra_q;
      OFF_AMASK: reg_rdata = am_q;
      OFF_DATA:  reg_rdata = rd_q;
      OFF_DMASK: reg_rdata = dm_q;
      OFF_CTL:   reg_rdata = {{PAD_W{1'b0}}, ctl_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign ref_addr_o  = ra_q;
  assign addr_mask_o = am_q;
  assign ref_data_o  = rd_q;
  assign data_mask_o = dm_q;
  assign ctl_o       = ctl_q;

  // R2: an address-register write is visible on the next cycle
  p_addr_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_ADDR) |=> (ref_addr_o == $past(reg_wdata)));

  // R2: a data-mask write is visible on the next cycle
  p_dmask_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_DMASK) |=> (data_mask_o == $past(reg_wdata)));

  // R11: no write strobe means every register holds its value
  p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(ref_addr_o) && $stable(ref_data_o) && $stable(ctl_o)));
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] mask,
  output logic          hit_o
);
  logic [AW-1:0] diff;

  always_comb begin
    diff  = (bus_addr ^ ref_addr) & ~mask;
    hit_o = (diff == '0);
  end

  // R3: a fully masked address always matches
  always_comb begin
    if (&mask) begin
      p_full_mask_hits_r3: assert (hit_o);
    end
  end

  // R3: an exact address always matches
  always_comb begin
    if (bus_addr == ref_addr) begin
      p_exact_addr_hits_r3: assert (hit_o);
    end
  end
endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
  import brk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] bus_data,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] mask,
  input  brk_size_e     size,
  input  logic          addr_lsb,
  output logic          hit_o
);
  localparam int NB          = DW / 8;
  localparam int WORD_BYTES  = 2;
  localparam int LANE_EVEN   = 1;  // byte at even address: bits 15:8
  localparam int LANE_ODD    = 0;  // byte at odd address:  bits 7:0

  logic [NB-1:0] lane_en;
  logic [NB-1:0] lane_ok;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0] d;
    assign d = (bus_data[8*i +: 8] ^ ref_data[8*i +: 8]) & ~mask[8*i +: 8];
    assign lane_en[i] = (size == SZ_LONG)
                      | ((size == SZ_WORD) & (i < WORD_BYTES))
                      | ((size == SZ_BYTE) & (addr_lsb ? (i == LANE_ODD) : (i == LANE_EVEN)));
    assign lane_ok[i] = !lane_en[i] || (d == 8'h00);
  end

  assign hit_o = &lane_ok;

  // R6/R7: a byte compare enables exactly one lane
  always_comb begin
    if (size == SZ_BYTE) begin
      p_byte_one_lane_r6: assert ($countones(lane_en) == 1);
    end
  end

  // R4: a fully masked data word always matches
  always_comb begin
    if (&mask) begin
      p_full_mask_hits_r4: assert (hit_o);
    end
  end
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           bus_valid,
  input  logic [DW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_data,
  input  logic [1:0]     bus_size,
  input  logic           bus_wr,
  output logic           brk_o
);
  localparam int SYNC_STAGES = 2;

  // reset: asserts asynchronously, releases on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [DW-1:0] ref_addr, addr_mask, ref_data, data_mask;
  brk_ctl_t      ctl;
  logic          addr_hit, data_hit;

  brk_regs #(.DW(DW), .RAW(RAW)) regs_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ref_addr_o (ref_addr),
    .addr_mask_o(addr_mask),
    .ref_data_o (ref_data),
    .data_mask_o(data_mask),
    .ctl_o      (ctl)
  );

  brk_addr_cmp #(.AW(DW)) acmp_i (
    .bus_addr(bus_addr),
    .ref_addr(ref_addr),
    .mask    (addr_mask),
    .hit_o   (addr_hit)
  );

  brk_data_cmp #(.DW(DW)) dcmp_i (
    .bus_data(bus_data),
    .ref_data(ref_data),
    .mask    (data_mask),
    .size    (ctl.size),
    .addr_lsb(bus_addr[0]),
    .hit_o   (data_hit)
  );

  logic size_ok, data_ok, kind_ok, brk_d, brk_q;

  always_comb begin
    size_ok = (ctl.size == SZ_NONE) || (bus_size == ctl.size);
    data_ok = !(ctl.data_en && (ctl.size != SZ_NONE)) || data_hit;
    kind_ok = bus_wr ? ctl.on_wr : ctl.on_rd;
    brk_d   = bus_valid && addr_hit && size_ok && data_ok && kind_ok;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) brk_q <= 1'b0;
    else            brk_q <= brk_d;
  end

  assign brk_o = brk_q;

  // R10: a pulse always follows a valid access
  p_pulse_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    brk_o |-> $past(bus_valid));

  // R9: a pulse needs an enabled access kind
  p_pulse_needs_kind_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    brk_o |-> $past(bus_wr ? ctl.on_wr : ctl.on_rd));

  // R8: a pulse under a selected size means the access had that size
  p_pulse_size_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (brk_o && $past(ctl.size) != SZ_NONE) |-> ($past(bus_size) == $past(ctl.size)));
endmodule

// File: tb/brk_cmp_top_tb.sv
`timescale 1ns/1ps
module brk_cmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bus_valid, bus_wr, brk_o;
  logic [31:0] bus_addr, bus_data;
  logic [1:0]  bus_size;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  brk_cmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
    .bus_wr(bus_wr), .brk_o(brk_o)
  );

  localparam logic [1:0] B = 2'd1, W = 2'd2, L = 2'd3;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = off; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = off;
    #1 check(tag, reg_rdata, exp);
  endtask

  // one access; pulse due one clock later, gone the clock after
  task automatic acc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                     input logic w, input logic exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = sz; bus_wr = w;
    @(negedge clk);
    bus_valid = 1'b0;
    check(tag, {31'd0, brk_o}, {31'd0, exp});
    @(negedge clk);
    if (exp) check({tag, " R10 single"}, {31'd0, brk_o}, 32'd0);
  endtask

  task automatic t_reset;
    rd(5'h00, 0, "R1 addr"); rd(5'h04, 0, "R1 amask"); rd(5'h08, 0, "R1 data");
    rd(5'h0C, 0, "R1 dmask"); rd(5'h10, 0, "R1 ctl");
    check("R1 brk", {31'd0, brk_o}, 32'd0);
    acc(32'h0, 32'h0, L, 1'b0, 1'b0, "R9 both kinds off");
  endtask

  task automatic t_regs;
    wr(5'h00, 32'h11112222); wr(5'h04, 32'h33334444); wr(5'h08, 32'h55556666);
    wr(5'h0C, 32'h77778888); wr(5'h10, 32'hFFFFFFFF);
    rd(5'h00, 32'h11112222, "R2 addr"); rd(5'h04, 32'h33334444, "R2 amask");
    rd(5'h08, 32'h55556666, "R2 data"); rd(5'h0C, 32'h77778888, "R2 dmask");
    rd(5'h10, 32'h0000001F, "R2 ctl");  rd(5'h14, 32'h0, "R2 unmapped");
  endtask

  task automatic t_addr;
    wr(5'h00, 32'h12345678); wr(5'h04, 0); wr(5'h0C, 0); wr(5'h10, 32'h18);
    acc(32'h12345678, 0, L, 1'b0, 1'b1, "R3 exact");
    acc(32'h12345679, 0, L, 1'b0, 1'b0, "R3 lsb differs");
    wr(5'h04, 32'h0000000F);
    acc(32'h1234567F, 0, L, 1'b0, 1'b1, "R3 masked nibble");
    acc(32'h1234577F, 0, L, 1'b0, 1'b0, "R3 unmasked bit");
  endtask

  task automatic t_long;
    wr(5'h04, 32'hFFFFFFFF); wr(5'h08, 32'hCAFEBABE); wr(5'h0C, 0); wr(5'h10, 32'h1F);
    acc(32'h0, 32'hCAFEBABE, L, 1'b1, 1'b1, "R4 equal");
    acc(32'h0, 32'hCAFEBABF, L, 1'b1, 1'b0, "R4 differ");
    acc(32'h0, 32'h4AFEBABE, L, 1'b1, 1'b0, "R4 msb differ");
    wr(5'h0C, 32'h00000001);
    acc(32'h0, 32'hCAFEBABF, L, 1'b1, 1'b1, "R4 masked bit");
  endtask

  task automatic t_word;
    wr(5'h08, 32'h0000BEEF); wr(5'h0C, 0); wr(5'h10, 32'h1E);
    acc(32'h2, 32'hFFFFBEEF, W, 1'b0, 1'b1, "R5 upper ignored");
    acc(32'h2, 32'h0000BEEE, W, 1'b0, 1'b0, "R5 low differs");
  endtask

  task automatic t_byte;
    wr(5'h08, 32'h00005A00); wr(5'h10, 32'h1D);
    acc(32'h100, 32'hFFFF5AFF, B, 1'b0, 1'b1, "R6 even lane");
    acc(32'h100, 32'h00005B00, B, 1'b0, 1'b0, "R6 even differs");
    wr(5'h08, 32'h000000A5);
    acc(32'h101, 32'hFFFFFFA5, B, 1'b0, 1'b1, "R7 odd lane");
    acc(32'h101, 32'h0000A500, B, 1'b0, 1'b0, "R7 wrong lane");
  endtask

  task automatic t_size;
    wr(5'h10, 32'h1B);
    acc(32'h0, 0, W, 1'b0, 1'b0, "R8 size mismatch");
    acc(32'h0, 0, L, 1'b0, 1'b1, "R8 size match");
    wr(5'h08, 32'h12345678); wr(5'h10, 32'h1C);
    acc(32'h0, 32'h87654321, B, 1'b0, 1'b1, "R8 no size data off");
  endtask

  task automatic t_kind;
    wr(5'h10, 32'h08);
    acc(32'h0, 0, L, 1'b0, 1'b1, "R9 read on");
    acc(32'h0, 0, L, 1'b1, 1'b0, "R9 write off");
    wr(5'h10, 32'h10);
    acc(32'h0, 0, L, 1'b1, 1'b1, "R9 write on");
    acc(32'h0, 0, L, 1'b0, 1'b0, "R9 read off");
  endtask

  task automatic t_timing;
    wr(5'h10, 32'h18);
    @(negedge clk);
    bus_valid = 1'b0; bus_addr = 0;
    @(negedge clk);
    check("R10 no valid no pulse", {31'd0, brk_o}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b1;
    #1 check("R10 not same cycle", {31'd0, brk_o}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R10 next cycle", {31'd0, brk_o}, 32'd1);
  endtask

  task automatic t_same_cycle;
    wr(5'h04, 0); wr(5'h00, 32'h100); wr(5'h10, 32'h18);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 32'h200; bus_data = 0; bus_size = L; bus_wr = 1'b0;
    reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h200;
    @(negedge clk);
    bus_valid = 1'b0; reg_we = 1'b0;
    check("R11 old value used", {31'd0, brk_o}, 32'd0);
    acc(32'h200, 0, L, 1'b0, 1'b1, "R11 new value next");
  endtask

  initial begin
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    bus_valid = 0; bus_addr = 0; bus_data = 0; bus_size = 0; bus_wr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset(); t_regs(); t_addr(); t_long(); t_word(); t_byte();
    t_size(); t_kind(); t_timing(); t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule